// File: doc/BRIEF.md
# Miss Tracking Queue

This block keeps a fixed pool of entries for cache misses that are still outstanding. Each entry holds a block address, a byte size, a thread tag, the earliest tick at which it may go out, and a flag that says whether a response will come back. The entries that wait to go to memory are kept in a pending order. The block offers the head of that order to the memory side once the head's ready tick has arrived. The memory side then moves entries into service, sends them back for another try, or frees them.

The pool is built larger than the usable size by the reserve minus one. The full flag goes high while the reserve is still untouched, so an operation that needs up to four entries at once can still get them. The cache controller sends one command per cycle on a single encoded command port. Two combinational lookups run at all times: an exact block-address match and a byte-range overlap check. Each returns the oldest allocated entry that qualifies.

Top module: `miss_track_queue`

## Requirements
- R1: The pool holds REQ_ENTRIES+RESERVE-1 physical entries. An allocate (cmd_op=1) takes the lowest-numbered free entry, and alloc_idx shows that number during the command cycle. alloc_count rises by one after the edge.
- R2: full is high exactly when alloc_count is greater than the physical count minus RESERVE. With the defaults that means 8 or more entries held. Allocation still succeeds while full is high, as long as a physical entry is free.
- R3: An allocate with no free physical entry raises alloc_err in that cycle and changes no state.
- R4: issue_valid and issue_idx present the head of the pending order, but only when that head's ready tick is not later than now_tick. Otherwise issue_valid is low.
- R5: next_ready_at shows the head's ready tick, or all ones when nothing is waiting. pending is high whenever some entry waits.
- R6: A serve command (cmd_op=2) on a waiting entry takes it out of the pending order and raises serve_count by one. If the entry expects no response, it is freed instead.
- R7: A retry command (cmd_op=3) on an in-service entry puts it back at the tail of the pending order and lowers serve_count.
- R8: A squash (cmd_op=6) frees every waiting entry whose thread tag equals cmd_tid. In-service entries of that thread stay allocated and still answer lookups.
- R9: A front command (cmd_op=4) makes a waiting entry the head of the pending order. It has no effect on an entry in service.
- R10: hit_exact and hit_exact_idx report the earliest-allocated entry whose block address equals look_addr.
- R11: hit_overlap and hit_overlap_idx report the earliest-allocated entry whose range [addr, addr+size) intersects [look_addr, look_addr+look_size).
- R12: A free command (cmd_op=5) on an allocated entry releases it, and alloc_count drops. Freeing an in-service entry also lowers serve_count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Command: 0 none, 1 allocate, 2 serve, 3 retry, 4 front, 5 free, 6 squash |
| cmd_idx | input | IW | Entry addressed by serve, retry, front and free |
| cmd_addr | input | ADDR_W | Block address for allocate |
| cmd_size | input | SIZE_W | Byte size for allocate |
| cmd_tid | input | TID_W | Thread tag for allocate and squash |
| cmd_ready_at | input | TICK_W | Earliest issue tick for allocate |
| cmd_needs_resp | input | 1 | Allocated entry expects a response |
| now_tick | input | TICK_W | Free-running tick count |
| look_addr | input | ADDR_W | Lookup address |
| look_size | input | SIZE_W | Lookup byte size for overlap |
| alloc_idx | output | IW | Entry an allocate would take |
| alloc_err | output | 1 | Allocate refused, pool exhausted |
| hit_exact | output | 1 | Exact address match found |
| hit_exact_idx | output | IW | Oldest exact-match entry |
| hit_overlap | output | 1 | Overlapping entry found |
| hit_overlap_idx | output | IW | Oldest overlapping entry |
| issue_valid | output | 1 | Head entry may be issued now |
| issue_idx | output | IW | Head of the pending order |
| next_ready_at | output | TICK_W | Head ready tick, or all ones |
| full | output | 1 | Reserve threshold reached |
| pending | output | 1 | Some entry is waiting |
| alloc_count | output | CW | Entries allocated |
| serve_count | output | CW | Entries in service |

## Verification
A corrupted age relation shows up as a wrong issue_idx, or as the wrong index from a lookup when duplicate addresses exist. It appears on the first cycle after the faulty update. A lost valid or in-service bit shows up at once in alloc_count, serve_count, pending or alloc_idx, because these outputs are derived straight from the entry flags. The scenarios use duplicate addresses with reused indices, moving to the front and retrying, squashing a mix of waiting and in-service entries, and filling the pool past the reserve threshold to exhaustion. Together they make each such fault visible within one cycle of the command that triggers it.

// File: rtl/mtq_pkg.sv
package mtq_pkg;
   typedef enum logic [2:0] {
      OP_NOP    = 3'd0,
      OP_ALLOC  = 3'd1,
      OP_SERVE  = 3'd2,
      OP_RETRY  = 3'd3,
      OP_FRONT  = 3'd4,
      OP_FREE   = 3'd5,
      OP_SQUASH = 3'd6
   } mtq_op_e;
endpackage

// File: rtl/mtq_free_pick.sv
module mtq_free_pick #(
   parameter int N  = 11,
   parameter int IW = 4
) (
   input  logic [N-1:0]  busy,
   output logic          any_free,
   output logic [IW-1:0] idx
);
   always_comb begin
      any_free = 1'b0;
      idx      = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            any_free = 1'b1;
            idx      = IW'(i);
         end
      end
   end
endmodule

// File: rtl/mtq_age_matrix.sv
module mtq_age_matrix #(
   parameter int N  = 11,
   parameter int IW = 4,
   parameter int NQ = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  push_en,
   input  logic [IW-1:0]         push_idx,
   input  logic                  front_en,
   input  logic [IW-1:0]         front_idx,
   input  logic [NQ-1:0][N-1:0]  member,
   output logic [NQ-1:0][N-1:0]  oldest_oh,
   output logic [NQ-1:0]         found
);
   // older_q[i][j] set: entry i precedes entry j
   logic [N-1:0][N-1:0] older_q, older_d;

   always_comb begin
      older_d = older_q;
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) begin
            if (i != j) begin
               if (push_en) begin
                  if (push_idx == IW'(i))      older_d[i][j] = 1'b0;
                  else if (push_idx == IW'(j)) older_d[i][j] = 1'b1;
               end
               if (front_en) begin
                  if (front_idx == IW'(i))      older_d[i][j] = 1'b1;
                  else if (front_idx == IW'(j)) older_d[i][j] = 1'b0;
               end
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) older_q <= '0;
      else        older_q <= older_d;
   end

   for (genvar q = 0; q < NQ; q++) begin : g_query
      logic [N-1:0] pick;
      always_comb begin
         for (int i = 0; i < N; i++) begin
            pick[i] = member[q][i];
            for (int j = 0; j < N; j++) begin
               if (j != i && member[q][j] && older_q[j][i]) pick[i] = 1'b0;
            end
         end
      end
      assign oldest_oh[q] = pick;
      assign found[q]     = |member[q];
   end
endmodule

// File: rtl/mtq_lookup.sv
module mtq_lookup #(
   parameter int N  = 11,
   parameter int AW = 32,
   parameter int SW = 8
) (
   input  logic [N-1:0]          vld,
   input  logic [N-1:0][AW-1:0]  addr,
   input  logic [N-1:0][SW-1:0]  size,
   input  logic [AW-1:0]         q_addr,
   input  logic [SW-1:0]         q_size,
   output logic [N-1:0]          exact_mask,
   output logic [N-1:0]          overlap_mask
);
   logic [AW:0] q_lo, q_hi;
   assign q_lo = {1'b0, q_addr};
   assign q_hi = q_lo + (AW+1)'(q_size);

   always_comb begin
      for (int i = 0; i < N; i++) begin
         logic [AW:0] e_lo, e_hi;
         e_lo = {1'b0, addr[i]};
         e_hi = e_lo + (AW+1)'(size[i]);
         exact_mask[i]   = vld[i] && (addr[i] == q_addr);
         overlap_mask[i] = vld[i] && (e_lo < q_hi) && (q_lo < e_hi);
      end
   end
endmodule

// File: rtl/miss_track_queue.sv
module miss_track_queue
   import mtq_pkg::*;
#(
   parameter int REQ_ENTRIES = 8,
   parameter int RESERVE     = 4,
   parameter int ADDR_W      = 32,
   parameter int SIZE_W      = 8,
   parameter int TID_W       = 2,
   parameter int TICK_W      = 16,
   localparam int PHYS       = REQ_ENTRIES + RESERVE - 1,
   localparam int IW         = (PHYS > 1) ? $clog2(PHYS) : 1,
   localparam int CW         = $clog2(PHYS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd_op,
   input  logic [IW-1:0]     cmd_idx,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [SIZE_W-1:0] cmd_size,
   input  logic [TID_W-1:0]  cmd_tid,
   input  logic [TICK_W-1:0] cmd_ready_at,
   input  logic              cmd_needs_resp,
   input  logic [TICK_W-1:0] now_tick,
   input  logic [ADDR_W-1:0] look_addr,
   input  logic [SIZE_W-1:0] look_size,
   output logic [IW-1:0]     alloc_idx,
   output logic              alloc_err,
   output logic              hit_exact,
   output logic [IW-1:0]     hit_exact_idx,
   output logic              hit_overlap,
   output logic [IW-1:0]     hit_overlap_idx,
   output logic              issue_valid,
   output logic [IW-1:0]     issue_idx,
   output logic [TICK_W-1:0] next_ready_at,
   output logic              full,
   output logic              pending,
   output logic [CW-1:0]     alloc_count,
   output logic [CW-1:0]     serve_count
);
   if (REQ_ENTRIES < 1) begin : g_bad_req
      $error("REQ_ENTRIES must be at least 1");
   end
   if (RESERVE < 1) begin : g_bad_res
      $error("RESERVE must be at least 1");
   end
   if (PHYS < 2) begin : g_bad_phys
      $error("pool needs at least two physical entries");
   end

   mtq_op_e op;
   assign op = mtq_op_e'(cmd_op);

   logic [PHYS-1:0]              vld_q, svc_q, resp_q;
   logic [PHYS-1:0][ADDR_W-1:0]  addr_q;
   logic [PHYS-1:0][SIZE_W-1:0]  size_q;
   logic [PHYS-1:0][TID_W-1:0]   tid_q;
   logic [PHYS-1:0][TICK_W-1:0]  rdy_q;

   // free slot selection
   logic          any_free;
   logic [IW-1:0] free_idx;
   mtq_free_pick #(.N(PHYS), .IW(IW)) u_pick (
      .busy(vld_q), .any_free(any_free), .idx(free_idx)
   );

   // command decode
   logic idx_ok, tgt_vld, tgt_svc, tgt_resp;
   logic alloc_go, serve_keep, serve_drop, retry_go, front_go, free_go;
   logic [PHYS-1:0] squash_hit;

   assign idx_ok   = {1'b0, cmd_idx} < (IW+1)'(PHYS);
   assign tgt_vld  = idx_ok && vld_q[cmd_idx];
   assign tgt_svc  = idx_ok && svc_q[cmd_idx];
   assign tgt_resp = idx_ok && resp_q[cmd_idx];

   assign alloc_go   = (op == OP_ALLOC) && any_free;
   assign alloc_err  = (op == OP_ALLOC) && !any_free;
   assign alloc_idx  = free_idx;
   assign serve_keep = (op == OP_SERVE) && tgt_vld && !tgt_svc && tgt_resp;
   assign serve_drop = (op == OP_SERVE) && tgt_vld && !tgt_svc && !tgt_resp;
   assign retry_go   = (op == OP_RETRY) && tgt_vld && tgt_svc;
   assign front_go   = (op == OP_FRONT) && tgt_vld && !tgt_svc;
   assign free_go    = (op == OP_FREE) && tgt_vld;

   always_comb begin
      for (int i = 0; i < PHYS; i++) begin
         squash_hit[i] = (op == OP_SQUASH) && vld_q[i] && !svc_q[i] &&
                         (tid_q[i] == cmd_tid);
      end
   end

   // entry state
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= '0;
         svc_q  <= '0;
         resp_q <= '0;
         addr_q <= '0;
         size_q <= '0;
         tid_q  <= '0;
         rdy_q  <= '0;
      end else begin
         for (int i = 0; i < PHYS; i++) begin
            if (alloc_go && free_idx == IW'(i)) begin
               vld_q[i]  <= 1'b1;
               svc_q[i]  <= 1'b0;
               resp_q[i] <= cmd_needs_resp;
               addr_q[i] <= cmd_addr;
               size_q[i] <= cmd_size;
               tid_q[i]  <= cmd_tid;
               rdy_q[i]  <= cmd_ready_at;
            end
            if (cmd_idx == IW'(i)) begin
               if (serve_drop || free_go) begin
                  vld_q[i] <= 1'b0;
                  svc_q[i] <= 1'b0;
               end
               if (serve_keep) svc_q[i] <= 1'b1;
               if (retry_go)   svc_q[i] <= 1'b0;
            end
            if (squash_hit[i]) vld_q[i] <= 1'b0;
         end
      end
   end

   // pending order
   logic [PHYS-1:0]          pend_mask;
   logic [0:0][PHYS-1:0]     pend_member, pend_oh;
   logic [0:0]               pend_found;
   assign pend_mask      = vld_q & ~svc_q;
   assign pend_member[0] = pend_mask;

   mtq_age_matrix #(.N(PHYS), .IW(IW), .NQ(1)) u_pend_age (
      .clk(clk), .rst_n(rst_n),
      .push_en(alloc_go || retry_go),
      .push_idx(alloc_go ? free_idx : cmd_idx),
      .front_en(front_go), .front_idx(cmd_idx),
      .member(pend_member), .oldest_oh(pend_oh), .found(pend_found)
   );

   // allocation order and lookups
   logic [PHYS-1:0]      exact_mask, overlap_mask;
   logic [1:0][PHYS-1:0] look_member, look_oh;
   logic [1:0]           look_found;

   mtq_lookup #(.N(PHYS), .AW(ADDR_W), .SW(SIZE_W)) u_look (
      .vld(vld_q), .addr(addr_q), .size(size_q),
      .q_addr(look_addr), .q_size(look_size),
      .exact_mask(exact_mask), .overlap_mask(overlap_mask)
   );

   assign look_member[0] = exact_mask;
   assign look_member[1] = overlap_mask;

   mtq_age_matrix #(.N(PHYS), .IW(IW), .NQ(2)) u_alloc_age (
      .clk(clk), .rst_n(rst_n),
      .push_en(alloc_go), .push_idx(free_idx),
      .front_en(1'b0), .front_idx('0),
      .member(look_member), .oldest_oh(look_oh), .found(look_found)
   );

   // one-hot to index, counts
   logic [IW-1:0] head_idx;
   always_comb begin
      head_idx        = '0;
      hit_exact_idx   = '0;
      hit_overlap_idx = '0;
      alloc_count     = '0;
      serve_count     = '0;
      for (int i = 0; i < PHYS; i++) begin
         if (pend_oh[0][i]) head_idx        = IW'(i);
         if (look_oh[0][i]) hit_exact_idx   = IW'(i);
         if (look_oh[1][i]) hit_overlap_idx = IW'(i);
         alloc_count = alloc_count + CW'(vld_q[i]);
         serve_count = serve_count + CW'(vld_q[i] & svc_q[i]);
      end
   end

   assign hit_exact     = look_found[0];
   assign hit_overlap   = look_found[1];
   assign pending       = pend_found[0];
   assign issue_idx     = head_idx;
   assign issue_valid   = pend_found[0] && (rdy_q[head_idx] <= now_tick);
   assign next_ready_at = pend_found[0] ? rdy_q[head_idx] : '1;
   assign full          = alloc_count > CW'(PHYS - RESERVE);
endmodule

// File: rtl/mtq_check.sv
module mtq_check #(
   parameter int REQ_ENTRIES = 8,
   parameter int RESERVE     = 4,
   parameter int TICK_W      = 16,
   localparam int PHYS       = REQ_ENTRIES + RESERVE - 1,
   localparam int CW         = $clog2(PHYS + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2:0]        cmd_op,
   input logic              alloc_err,
   input logic              full,
   input logic              pending,
   input logic              issue_valid,
   input logic [TICK_W-1:0] next_ready_at,
   input logic [TICK_W-1:0] now_tick,
   input logic [CW-1:0]     alloc_count,
   input logic [CW-1:0]     serve_count
);
   AST_ALLOC_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd1 && !alloc_err) |=> alloc_count == $past(alloc_count) + CW'(1)); // R1
   AST_FULL_MEANS_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> alloc_count >= CW'(REQ_ENTRIES)); // R2
   AST_ERR_ONLY_EXHAUSTED: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_err |-> (full && alloc_count == CW'(PHYS))); // R3
   AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_err |=> alloc_count == $past(alloc_count)); // R3
   AST_ISSUE_RIPE: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid |-> (pending && next_ready_at <= now_tick)); // R4
   AST_IDLE_MAXTIME: assert property (@(posedge clk) disable iff (!rst_n)
      !pending |-> (!issue_valid && next_ready_at == '1)); // R5
   AST_SERVE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      serve_count <= alloc_count); // R6
   AST_SERVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == 3'd2) |=> serve_count <= $past(serve_count) + CW'(1)); // R6
endmodule

bind miss_track_queue mtq_check #(
   .REQ_ENTRIES(REQ_ENTRIES), .RESERVE(RESERVE), .TICK_W(TICK_W)
) u_mtq_check (
   .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .alloc_err(alloc_err),
   .full(full), .pending(pending), .issue_valid(issue_valid),
   .next_ready_at(next_ready_at), .now_tick(now_tick),
   .alloc_count(alloc_count), .serve_count(serve_count)
);

// File: tb/tb_miss_track_queue.sv
module tb_miss_track_queue;
   localparam int IW = 4;
   localparam int CW = 4;
   localparam int AW = 32;
   localparam int SW = 8;
   localparam int TW = 2;
   localparam int KW = 16;

   localparam int S_AIDX = 0, S_AERR = 1, S_CNT = 2, S_SVC = 3, S_FULL = 4,
                  S_PEND = 5, S_IV = 6, S_II = 7, S_NRT = 8, S_HE = 9,
                  S_HEI = 10, S_HO = 11, S_HOI = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    cmd_op = '0;
   logic [IW-1:0] cmd_idx = '0;
   logic [AW-1:0] cmd_addr = '0;
   logic [SW-1:0] cmd_size = '0;
   logic [TW-1:0] cmd_tid = '0;
   logic [KW-1:0] cmd_ready_at = '0;
   logic          cmd_needs_resp = 1'b0;
   logic [KW-1:0] now_tick;
   logic [AW-1:0] look_addr = '0;
   logic [SW-1:0] look_size = '0;
   logic [IW-1:0] alloc_idx, hit_exact_idx, hit_overlap_idx, issue_idx;
   logic          alloc_err, hit_exact, hit_overlap, issue_valid, full, pending;
   logic [KW-1:0] next_ready_at;
   logic [CW-1:0] alloc_count, serve_count;

   miss_track_queue dut (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
      .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_tid(cmd_tid),
      .cmd_ready_at(cmd_ready_at), .cmd_needs_resp(cmd_needs_resp),
      .now_tick(now_tick), .look_addr(look_addr), .look_size(look_size),
      .alloc_idx(alloc_idx), .alloc_err(alloc_err), .hit_exact(hit_exact),
      .hit_exact_idx(hit_exact_idx), .hit_overlap(hit_overlap),
      .hit_overlap_idx(hit_overlap_idx), .issue_valid(issue_valid),
      .issue_idx(issue_idx), .next_ready_at(next_ready_at), .full(full),
      .pending(pending), .alloc_count(alloc_count), .serve_count(serve_count)
   );

   always #5 clk = ~clk;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now_tick <= '0;
      else        now_tick <= now_tick + 16'd1;
   end

   typedef struct {
      int          sig;
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t sb[$];
   int    total = 0;
   int    bad = 0;
   bit    done = 0;

   function automatic logic [31:0] sample(int s);
      case (s)
         S_AIDX:  return 32'(alloc_idx);
         S_AERR:  return 32'(alloc_err);
         S_CNT:   return 32'(alloc_count);
         S_SVC:   return 32'(serve_count);
         S_FULL:  return 32'(full);
         S_PEND:  return 32'(pending);
         S_IV:    return 32'(issue_valid);
         S_II:    return 32'(issue_idx);
         S_NRT:   return 32'(next_ready_at);
         S_HE:    return 32'(hit_exact);
         S_HEI:   return 32'(hit_exact_idx);
         S_HO:    return 32'(hit_overlap);
         default: return 32'(hit_overlap_idx);
      endcase
   endfunction

   task automatic push_exp(int s, logic [31:0] e, string r);
      item_t it;
      it.sig = s; it.exp = e; it.req = r;
      sb.push_back(it);
   endtask

   // monitor: compare queued expectations away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it  = sb.pop_front();
            act = sample(it.sig);
            total++;
            if (act !== it.exp) begin
               bad++;
               $display("FAIL %s sig=%0d actual=%0h expected=%0h", it.req, it.sig, act, it.exp);
            end
         end
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
      cmd_op = 3'd0;
   endtask

   task automatic state(int cnt, int svc, int fl, int pd, int iv, int ii,
                        logic [31:0] nrt, string r);
      push_exp(S_CNT, 32'(cnt), r);
      push_exp(S_SVC, 32'(svc), r);
      push_exp(S_FULL, 32'(fl), r);
      push_exp(S_PEND, 32'(pd), r);
      push_exp(S_IV, 32'(iv), r);
      if (iv != 0) push_exp(S_II, 32'(ii), r);
      push_exp(S_NRT, nrt, r);
   endtask

   task automatic alloc(logic [31:0] a, logic [7:0] sz, logic [1:0] t,
                        logic [15:0] rdy, logic rsp, int exp_idx, int exp_err, string r);
      cmd_op = 3'd1; cmd_addr = a; cmd_size = sz; cmd_tid = t;
      cmd_ready_at = rdy; cmd_needs_resp = rsp;
      push_exp(S_AERR, 32'(exp_err), r);
      if (exp_err == 0) push_exp(S_AIDX, 32'(exp_idx), r);
      step();
   endtask

   task automatic cmd(logic [2:0] o, int idx, logic [1:0] t);
      cmd_op = o; cmd_idx = IW'(idx); cmd_tid = t;
      step();
   endtask

   task automatic look(logic [31:0] a, logic [7:0] sz, int he, int hei,
                       int ho, int hoi, string r);
      look_addr = a; look_size = sz;
      push_exp(S_HE, 32'(he), r);
      if (he != 0) push_exp(S_HEI, 32'(hei), r);
      push_exp(S_HO, 32'(ho), r);
      if (ho != 0) push_exp(S_HOI, 32'(hoi), r);
      step();
   endtask

   localparam logic [31:0] NONE = 32'h0000_FFFF;

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      state(0, 0, 0, 0, 0, 0, NONE, "R5 reset");
      step();

      // R1 R4 basic allocation
      alloc(32'h100, 8'd64, 2'd1, 16'h0,    1'b1, 0, 0, "R1");
      state(1, 0, 0, 1, 1, 0, 0, "R4 head ready");
      alloc(32'h200, 8'd64, 2'd2, 16'hFFF0, 1'b1, 1, 0, "R1");
      alloc(32'h100, 8'd32, 2'd1, 16'h0,    1'b0, 2, 0, "R1");
      state(3, 0, 0, 1, 1, 0, 0, "R4 head unchanged");

      // R10 R11 lookups
      look(32'h100, 8'd1,    1, 0, 1, 0, "R10 oldest dup");
      look(32'h1F0, 8'h20,   0, 0, 1, 1, "R11 upper");
      look(32'h120, 8'h10,   0, 0, 1, 0, "R11 edge");
      look(32'h140, 8'h10,   0, 0, 0, 0, "R11 no overlap");

      // R6 serve, R4 gating by ready tick
      cmd(3'd2, 0, 2'd0);
      state(3, 1, 0, 1, 0, 0, 32'hFFF0, "R6 serve");
      // R9 front
      cmd(3'd4, 2, 2'd0);
      state(3, 1, 0, 1, 1, 2, 0, "R9 front");
      cmd(3'd4, 0, 2'd0);
      state(3, 1, 0, 1, 1, 2, 0, "R9 in-service front ignored");
      // R6 serve with no response frees
      cmd(3'd2, 2, 2'd0);
      state(2, 1, 0, 1, 0, 0, 32'hFFF0, "R6 no-response freed");
      // R7 retry goes to tail
      cmd(3'd3, 0, 2'd0);
      state(2, 0, 0, 1, 0, 0, 32'hFFF0, "R7 retry tail");
      cmd(3'd5, 1, 2'd0);
      state(1, 0, 0, 1, 1, 0, 0, "R7 R12 after free");

      // R8 squash
      cmd(3'd2, 0, 2'd0);
      state(1, 1, 0, 0, 0, 0, NONE, "R6 serve again");
      alloc(32'h300, 8'd16, 2'd1, 16'h0, 1'b1, 1, 0, "R1 lowest free");
      alloc(32'h400, 8'd16, 2'd3, 16'h0, 1'b1, 2, 0, "R1 lowest free");
      cmd(3'd6, 0, 2'd1);
      state(2, 1, 0, 1, 1, 2, 0, "R8 squash");
      look(32'h100, 8'd1, 1, 0, 1, 0, "R8 in-service kept");
      look(32'h300, 8'd1, 0, 0, 0, 0, "R8 waiting freed");

      // R12 free in-service and waiting
      cmd(3'd5, 0, 2'd0);
      state(1, 0, 0, 1, 1, 2, 0, "R12 free in-service");
      cmd(3'd5, 2, 2'd0);
      state(0, 0, 0, 0, 0, 0, NONE, "R12 free last");

      // R10 age beats index
      alloc(32'h500, 8'd8, 2'd0, 16'h0, 1'b1, 0, 0, "R1");
      alloc(32'h600, 8'd8, 2'd0, 16'h0, 1'b1, 1, 0, "R1");
      cmd(3'd5, 0, 2'd0);
      alloc(32'h600, 8'd8, 2'd0, 16'h0, 1'b1, 0, 0, "R1 reuse");
      look(32'h600, 8'd1, 1, 1, 1, 1, "R10 R11 age order");
      cmd(3'd5, 0, 2'd0);
      cmd(3'd5, 1, 2'd0);
      state(0, 0, 0, 0, 0, 0, NONE, "R12 empty");

      // R2 R3 fill to exhaustion
      for (int k = 0; k < 11; k++) begin
         alloc(32'h1000 + 32'(k) * 32'h40, 8'd64, 2'd0, 16'hFFF0, 1'b1, k, 0, "R1 fill");
         state(k + 1, 0, (k + 1 >= 8) ? 1 : 0, 1, 0, 0, 32'hFFF0, "R2 threshold");
      end
      alloc(32'h9000, 8'd64, 2'd0, 16'h0, 1'b1, 0, 1, "R3 exhausted");
      state(11, 0, 1, 1, 0, 0, 32'hFFF0, "R3 no change");
      look(32'h9000, 8'd1, 0, 0, 0, 0, "R3 nothing stored");

      repeat (2) @(posedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog all-R actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule